// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is the eight-bit control and status register a small microcontroller core uses to drive flash self-programming. Software writes it over a simple register bus to choose an operation (page erase, page write, lock-bit set, busy-flag clear, temporary page-buffer load, or a read of the device signature row) and to arm a short acceptance window. The core decodes store-program and load-program instructions and presents each one as a one-cycle strobe. A strobe that lands inside an open window is accepted, and the block emits a one-cycle pulse that names the chosen operation.

Erase and write are long operations. They stay in progress until a modeled flash engine returns a done pulse, and they raise a busy flag that blocks reads of the rewritable flash section. The register also raises a ready interrupt whenever its interrupt enable and the core's global interrupt flag are both set and no operation is armed or running. When a window lapses or an operation finishes, the arming bit and the selection bits clear themselves.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, every register bit reads 0, and `ready_irq` and `rww_block` are both 0. The read layout from bit 7 down to bit 0 is: interrupt enable, busy, signature select, busy-clear select, lock select, write select, erase select, arm.
- R2: Bit 6 (busy) is read-only. A bus write that carries 1 in bit 6 leaves it unchanged.
- R3: `ready_irq` is 1 exactly while interrupt enable (bit 7) is 1, `gie` is 1 and arm (bit 0) is 0.
- R4: An accepted page erase or page write sets busy and `rww_block`, and it stays in progress until `flash_done`. Arm and the select bits stay set until that pulse arrives.
- R5: While an erase or write is in progress, bus writes change only bit 7, so a busy-clear request written then has no effect. After completion, an accepted busy-clear operation clears busy.
- R6: An accepted page-buffer load clears busy.
- R7: A write that sets bits 5 and 0 together opens a load window. A `ld_strobe` 1 to 3 cycles after that write gives a `sig_read` pulse. A `ld_strobe` 4 cycles after it, or any `st_strobe` in that window, gives no operation.
- R8: A write that sets bit 0 without bit 5 opens a store window. A `st_strobe` 1 to 4 cycles after that write is accepted. A `st_strobe` 5 cycles after it is ignored.
- R9: When a window lapses with no accepted instruction, bits 5..0 clear at the 4th (store) or 3rd (load) edge after the write. Bits 5..0 also clear when a quick operation is accepted and when `flash_done` ends an erase or write.
- R10: When several select bits are set, the accepted store follows a fixed priority: erase (bit 1), then write (bit 2), then lock (bit 3), then busy-clear (bit 4). With none of them set, the accepted store is a buffer load. At most one operation pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| gie | input | 1 | Global interrupt flag of the core |
| st_strobe | input | 1 | Store-program instruction executed |
| ld_strobe | input | 1 | Load-program instruction executed |
| flash_done | input | 1 | Flash engine finished erase or write |
| op_erase | output | 1 | Page erase accepted (one-cycle pulse) |
| op_write | output | 1 | Page write accepted (one-cycle pulse) |
| op_lock | output | 1 | Lock-bit set accepted (one-cycle pulse) |
| op_bclr | output | 1 | Busy-clear accepted (one-cycle pulse) |
| op_load | output | 1 | Page-buffer load accepted (one-cycle pulse) |
| sig_read | output | 1 | Load instruction redirected to signature row (pulse) |
| ready_irq | output | 1 | Ready interrupt request |
| rww_block | output | 1 | Blocks reads of the rewritable section |

## Verification
The checker watches four things on every cycle. The interrupt never asserts without the global flag or while arm is set. Busy rises only alongside an erase or write pulse and falls only alongside a load or busy-clear pulse. The operation pulses are mutually exclusive and last one cycle. A signature read leaves bits 5..0 cleared. The exact window edges, the precedence among select bits, and the fact that a busy-clear is ignored while an operation is running all depend on the order of stimulus, so only the bench's scenarios can show them. The bench drives each window just inside and just past its boundary and compares each operation pulse against a queue of expected operations.

// File: rtl/selfprog_pkg.sv
// Shared definitions for the flash self-programming control register.
// Assumes an 8-bit register whose bit positions are decoded by software.
package selfprog_pkg;
    localparam int REG_W  = 8;
    localparam int B_IE   = 7;
    localparam int B_BUSY = 6;
    localparam int B_SIG  = 5;
    localparam int B_BCLR = 4;
    localparam int B_LOCK = 3;
    localparam int B_PWRT = 2;
    localparam int B_PERS = 1;
    localparam int B_EN   = 0;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ERASE = 3'd2,
        OP_WRITE = 3'd3,
        OP_LOCK  = 3'd4,
        OP_BCLR  = 3'd5,
        OP_SIG   = 3'd6
    } op_e;
endpackage

// File: rtl/selfprog_window.sv
// Acceptance window timer. An arm request loads a down-counter with the
// store or load window length. The window stays open while the counter is
// non-zero. A consume input closes it early. Expire pulses when the last
// open cycle passes with nothing consumed and no new arm.
// Assumes arm and consume are never both requested for the same edge.
module selfprog_window #(
    parameter int ST_WIN = 4,
    parameter int LD_WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic arm_ld,
    input  logic consume,
    output logic open_st,
    output logic open_ld,
    output logic expire
);
    localparam int MAXW = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN;
    localparam int CW   = $clog2(MAXW + 1);

    logic [CW-1:0] cnt;
    logic          mode_ld;

    // Load, cancel or count down the window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            mode_ld <= 1'b0;
        end else if (arm) begin
            cnt     <= arm_ld ? CW'(LD_WIN) : CW'(ST_WIN);
            mode_ld <= arm_ld;
        end else if (consume) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Decode the open and lapse conditions from the counter.
    always_comb begin
        open_st = (cnt != '0) && !mode_ld;
        open_ld = (cnt != '0) && mode_ld;
        expire  = (cnt == CW'(1)) && !consume && !arm;
    end
endmodule

// File: rtl/selfprog_opsel.sv
// Fixed-priority operation selector. It maps the select bits held in the
// register to a single operation. Erase outranks write, write outranks
// lock, and lock outranks busy-clear. With no bit set the result is a
// page-buffer load. Purely combinational.
module selfprog_opsel
    import selfprog_pkg::*;
(
    input  logic pers,
    input  logic pwrt,
    input  logic lock,
    input  logic bclr,
    output op_e  op
);
    // Later assignments override earlier ones, so the last line has top priority.
    always_comb begin
        op = OP_LOAD;
        if (bclr) op = OP_BCLR;
        if (lock) op = OP_LOCK;
        if (pwrt) op = OP_WRITE;
        if (pers) op = OP_ERASE;
    end
endmodule

// File: rtl/selfprog_busy.sv
// Busy flag of the rewritable flash section. It is set when an erase or
// write starts and cleared by a buffer load. It is also cleared by a
// busy-clear request, but only when no operation is in progress.
// Assumes set and the clear requests are mutually exclusive.
module selfprog_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_load,
    input  logic clr_req,
    input  logic op_active,
    output logic busy
);
    // Apply the set and clear rules to the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (set_req)
            busy <= 1'b1;
        else if (clr_load || (clr_req && !op_active))
            busy <= 1'b0;
    end
endmodule

// File: rtl/selfprog_ctrl.sv
// Flash self-programming control and status register. It holds the
// interrupt enable, arm and operation-select bits written by the core. It
// opens timed windows for store and load instructions, reports the accepted
// operation as a one-cycle pulse, tracks the busy flag of the rewritable
// section and requests the ready interrupt.
// Assumes st_strobe, ld_strobe and flash_done are one-cycle pulses that are
// synchronous to clk.
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int ST_WIN = 4,
    parameter int LD_WIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] rd_data,
    input  logic             gie,
    input  logic             st_strobe,
    input  logic             ld_strobe,
    input  logic             flash_done,
    output logic             op_erase,
    output logic             op_write,
    output logic             op_lock,
    output logic             op_bclr,
    output logic             op_load,
    output logic             sig_read,
    output logic             ready_irq,
    output logic             rww_block
);
    localparam int SEL_W = B_SIG - B_EN + 1;

    logic             ie;
    logic [SEL_W-1:0] sel;
    logic             active;
    logic             busy;
    logic             wr_eff;
    logic             arm;
    logic             cancel;
    logic             open_st;
    logic             open_ld;
    logic             expire;
    logic             st_acc;
    logic             ld_acc;
    logic             long_op;
    logic             clear_sel;
    op_e              sel_op;

    // Qualify bus writes, instruction acceptance and self-clear events.
    always_comb begin
        wr_eff    = bus_wr && !active;
        arm       = wr_eff && bus_wdata[B_EN];
        cancel    = wr_eff && !bus_wdata[B_EN];
        st_acc    = st_strobe && open_st && !wr_eff;
        ld_acc    = ld_strobe && open_ld && !wr_eff;
        long_op   = st_acc && ((sel_op == OP_ERASE) || (sel_op == OP_WRITE));
        clear_sel = (st_acc && !long_op) || ld_acc || expire
                    || (active && flash_done);
    end

    selfprog_window #(
        .ST_WIN (ST_WIN),
        .LD_WIN (LD_WIN)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .arm_ld  (bus_wdata[B_SIG]),
        .consume (st_acc || ld_acc || cancel),
        .open_st (open_st),
        .open_ld (open_ld),
        .expire  (expire)
    );

    selfprog_opsel u_opsel (
        .pers (sel[B_PERS - B_EN]),
        .pwrt (sel[B_PWRT - B_EN]),
        .lock (sel[B_LOCK - B_EN]),
        .bclr (sel[B_BCLR - B_EN]),
        .op   (sel_op)
    );

    selfprog_busy u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (long_op),
        .clr_load  (st_acc && (sel_op == OP_LOAD)),
        .clr_req   (st_acc && (sel_op == OP_BCLR)),
        .op_active (active),
        .busy      (busy)
    );

    // Interrupt enable is always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie <= 1'b0;
        else if (bus_wr)
            ie <= bus_wdata[B_IE];
    end

    // Arm and select bits: written when idle, self-cleared on completion or lapse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (wr_eff)
            sel <= bus_wdata[B_SIG:B_EN];
        else if (clear_sel)
            sel <= '0;
    end

    // Track an erase or write that is in progress until the engine reports done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (long_op)
            active <= 1'b1;
        else if (flash_done)
            active <= 1'b0;
    end

    // Register the one-cycle operation pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_erase <= 1'b0;
            op_write <= 1'b0;
            op_lock  <= 1'b0;
            op_bclr  <= 1'b0;
            op_load  <= 1'b0;
            sig_read <= 1'b0;
        end else begin
            op_erase <= st_acc && (sel_op == OP_ERASE);
            op_write <= st_acc && (sel_op == OP_WRITE);
            op_lock  <= st_acc && (sel_op == OP_LOCK);
            op_bclr  <= st_acc && (sel_op == OP_BCLR);
            op_load  <= st_acc && (sel_op == OP_LOAD);
            sig_read <= ld_acc;
        end
    end

    // Assemble the read view and the status outputs.
    always_comb begin
        rd_data         = '0;
        rd_data[B_IE]   = ie;
        rd_data[B_BUSY] = busy;
        rd_data[B_SIG:B_EN] = sel;
        ready_irq       = ie && gie && !sel[0];
        rww_block       = busy;
    end
endmodule

// Cycle-by-cycle properties of the control register.
module selfprog_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic       gie,
    input logic       op_erase,
    input logic       op_write,
    input logic       op_lock,
    input logic       op_bclr,
    input logic       op_load,
    input logic       sig_read,
    input logic       ready_irq,
    input logic       rww_block
);
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_irq |-> gie); // R3
    AST_IRQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_irq |-> (rd_data[7] && !rd_data[0])); // R3
    AST_BUSY_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rww_block) |-> (op_erase || op_write)); // R4
    AST_BUSY_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rww_block) |-> (op_load || op_bclr)); // R5
    AST_LOAD_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_load |-> !rww_block); // R6
    AST_SIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sig_read |-> (rd_data[5:0] == 6'd0)); // R7
    AST_OP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_erase || op_write) |=> !(op_erase || op_write)); // R8
    AST_OP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_erase, op_write, op_lock, op_bclr, op_load, sig_read})); // R10
endmodule

bind selfprog_ctrl selfprog_ctrl_chk u_chk (.*);

// File: tb/selfprog_ctrl_test.sv
// Scoreboard bench: the driver pushes expected operations, the monitor pops and compares.
module selfprog_ctrl_test;
    import selfprog_pkg::*;

    typedef struct {
        op_e   op;
        string req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       gie = 1'b0;
    logic       st_strobe = 1'b0;
    logic       ld_strobe = 1'b0;
    logic       flash_done = 1'b0;
    logic       op_erase, op_write, op_lock, op_bclr, op_load, sig_read;
    logic       ready_irq, rww_block;

    int    n_run  = 0;
    int    n_fail = 0;
    item_t expq[$];

    always #2 clk = ~clk;

    selfprog_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .rd_data    (rd_data),
        .gie        (gie),
        .st_strobe  (st_strobe),
        .ld_strobe  (ld_strobe),
        .flash_done (flash_done),
        .op_erase   (op_erase),
        .op_write   (op_write),
        .op_lock    (op_lock),
        .op_bclr    (op_bclr),
        .op_load    (op_load),
        .sig_read   (sig_read),
        .ready_irq  (ready_irq),
        .rww_block  (rww_block)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input logic [7:0] exp, input string req);
        check(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic expect_op(input op_e op, input string req);
        item_t it;
        it.op  = op;
        it.req = req;
        expq.push_back(it);
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic st_pulse(input int delay);
        repeat (delay) @(negedge clk);
        st_strobe = 1'b1;
        @(negedge clk);
        st_strobe = 1'b0;
    endtask

    task automatic ld_pulse(input int delay);
        repeat (delay) @(negedge clk);
        ld_strobe = 1'b1;
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    task automatic done_pulse();
        flash_done = 1'b1;
        @(negedge clk);
        flash_done = 1'b0;
    endtask

    // Monitor: encode each operation pulse and compare it with the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            op_e obs;
            obs = OP_NONE;
            if (op_erase) obs = OP_ERASE;
            if (op_write) obs = OP_WRITE;
            if (op_lock)  obs = OP_LOCK;
            if (op_bclr)  obs = OP_BCLR;
            if (op_load)  obs = OP_LOAD;
            if (sig_read) obs = OP_SIG;
            if (obs != OP_NONE) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R8 unexpected op", int'(obs), int'(OP_NONE));
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    check(obs == it.op, it.req, int'(obs), int'(it.op));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_reg(8'h00, "R1 reset reg");
        check(ready_irq == 1'b0 && rww_block == 1'b0, "R1 reset outputs",
              {ready_irq, rww_block}, 0);

        // R2: busy bit is read-only
        wr(8'h40);
        chk_reg(8'h00, "R2 busy read-only");

        // R3: interrupt conditions
        wr(8'h80);
        gie = 1'b0;
        @(negedge clk);
        check(ready_irq == 1'b0, "R3 irq without gie", ready_irq, 0);
        gie = 1'b1;
        @(negedge clk);
        check(ready_irq == 1'b1, "R3 irq idle", ready_irq, 1);
        wr(8'h81);
        check(ready_irq == 1'b0, "R3 irq masked by arm", ready_irq, 0);
        expect_op(OP_LOAD, "R10 plain load");
        st_pulse(0);
        chk_reg(8'h80, "R9 load self-clear");
        check(ready_irq == 1'b1, "R3 irq after load", ready_irq, 1);

        // R4: erase at the last store-window cycle, busy set, arm held
        wr(8'h83);
        expect_op(OP_ERASE, "R8 erase at cycle 4");
        st_pulse(3);
        chk_reg(8'hC3, "R4 erase in progress");
        check(rww_block == 1'b1, "R4 rww blocked", rww_block, 1);
        check(ready_irq == 1'b0, "R3 irq during op", ready_irq, 0);

        // R5: busy-clear request ignored while running
        wr(8'h91);
        st_pulse(0);
        chk_reg(8'hC3, "R5 write ignored during op");
        done_pulse();
        chk_reg(8'hC0, "R9 done self-clear");
        check(ready_irq == 1'b1, "R3 irq after done", ready_irq, 1);
        wr(8'h91);
        expect_op(OP_BCLR, "R5 busy clear op");
        st_pulse(0);
        chk_reg(8'h80, "R5 busy cleared");

        // R6: buffer load clears busy after a write
        wr(8'h05);
        expect_op(OP_WRITE, "R4 page write");
        st_pulse(1);
        chk_reg(8'h45, "R4 write in progress");
        done_pulse();
        chk_reg(8'h40, "R4 busy held after done");
        wr(8'h01);
        expect_op(OP_LOAD, "R6 load op");
        st_pulse(2);
        chk_reg(8'h00, "R6 load clears busy");

        // R8/R9: store window lapse
        wr(8'h03);
        repeat (3) @(negedge clk);
        chk_reg(8'h03, "R9 still armed at 3");
        @(negedge clk);
        chk_reg(8'h00, "R9 lapse clears");
        wr(8'h03);
        st_pulse(4);
        chk_reg(8'h00, "R8 late store ignored");
        check(rww_block == 1'b0, "R8 no busy from late store", rww_block, 0);

        // R7: signature window
        wr(8'h21);
        expect_op(OP_SIG, "R7 signature read");
        ld_pulse(2);
        chk_reg(8'h00, "R7 sig self-clear");
        wr(8'h21);
        ld_pulse(3);
        chk_reg(8'h00, "R7 late load ignored");
        wr(8'h21);
        st_pulse(0);
        repeat (3) @(negedge clk);
        chk_reg(8'h00, "R7 store in load window ignored");

        // R10: priority among select bits
        wr(8'h1F);
        expect_op(OP_ERASE, "R10 erase wins");
        st_pulse(0);
        done_pulse();
        chk_reg(8'h40, "R10 after erase");
        wr(8'h1D);
        expect_op(OP_WRITE, "R10 write over lock");
        st_pulse(0);
        done_pulse();
        wr(8'h19);
        expect_op(OP_LOCK, "R10 lock over bclr");
        st_pulse(0);
        chk_reg(8'h40, "R10 lock keeps busy");
        wr(8'h11);
        expect_op(OP_BCLR, "R10 bclr alone");
        st_pulse(0);
        chk_reg(8'h00, "R5 bclr after done");

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R10 all expected ops seen", expq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule